// File: doc/BRIEF.md
# Receive Page Ring Write Manager

This block steers the byte writes of a receive DMA channel into a ring of 256-byte pages held in buffer memory. Two static page numbers bound the ring: a first page and a stop page one past the last usable page. Two working page numbers follow the traffic. The current page marks where the next frame will start, and acts as the write pointer. The boundary page marks the oldest page software has not yet consumed, and acts as the read pointer. Each incoming byte strobe produces one memory write at the next ring address. When a page fills and more data follows, the block moves to the next page. It wraps past the stop page and gives up if the move would land on the boundary.

The first four bytes of the first page of every frame are reserved for a header. When a frame ends and is accepted, the block goes back and fills that header: a status byte, the page where the following frame will begin, and the 16-bit count of stored bytes. It then moves the current page to that following page. A rejected frame leaves no trace, because the next frame simply starts again at the unchanged current page. A frame that runs into the boundary is dropped, all earlier frames are left intact, and an overflow flag blocks further reception until software clears it.

Top module: `rxr_pager`

## Requirements
- R1: Every write address has a page number (address bits 15:8) in the range first page (inclusive) to stop page (exclusive). The page following stop-1 is the first page, both when linking and when forming the next-frame pointer.
- R2: The first byte of a frame is written to offset 4 of the current page, and each further byte goes to the next byte address. A byte strobed at a clock edge appears on `wr_en`/`wr_addr`/`wr_data` right after that edge; cycles without a strobe produce no write.
- R3: Linking happens only when a byte arrives after offset 255 of a page has been written. The next page is first wrapped at the stop page, then compared with the boundary. A frame that ends exactly at offset 255 links nothing and cannot abort.
- R4: After an accepted end of frame, four writes in the next four cycles fill offsets 0,1,2,3 of the frame's first page. They carry the status (bit0 = frame good, bit1 = bad frame kept), the next-frame page, the byte-count low byte and the byte-count high byte. The count is the number of bytes stored, check-sequence bytes included.
- R5: The next-frame page is the page after the last page written, wrapped per R1. `cur_page` takes that value in the same cycle the fourth header write appears.
- R6: An end of frame with `rx_good`=0 while `cfg_keep_bad`=0 produces no header and leaves `cur_page` unchanged, so the next frame reuses the same first page.
- R7: With `cfg_keep_bad`=1, a bad frame is stored with a header whose status byte is 2.
- R8: When a link would reach the boundary, the byte that needed the link is not written, `rx_abort` pulses for one cycle and `ovf` rises in that same cycle, no header is written, and `cur_page` is unchanged.
- R9: While `ovf` is 1, byte strobes and ends of frame cause no write. `ovf_clr` drops `ovf` on the next edge, after which the next frame starts at offset 4 of `cur_page`.
- R10: A boundary update (`bnd_we`) takes effect for link checks from the following cycle onward.
- R11: After reset, `cur_page` and the boundary equal `cfg_start`, `ovf` and `rx_abort` are 0, and no write is issued.
- R12: Byte strobes while the header is being written, an end of frame outside a frame, and a byte strobe in the same cycle as an end of frame are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_start | input | 8 | First page of the ring |
| cfg_stop | input | 8 | Page one past the last ring page |
| cfg_keep_bad | input | 1 | Store bad frames with a header instead of discarding them |
| bnd_we | input | 1 | Load a new boundary page |
| bnd_page | input | 8 | New boundary page value |
| rx_vld | input | 1 | One received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | End of the current frame |
| rx_good | input | 1 | Frame status with `rx_eof`: 1 = no error |
| ovf_clr | input | 1 | Clear the overflow flag and resume |
| wr_en | output | 1 | Memory byte write strobe |
| wr_addr | output | 16 | Memory byte address {page, offset} |
| wr_data | output | 8 | Memory write data (frame byte or header byte) |
| rx_abort | output | 1 | One-cycle pulse when a frame is dropped at the boundary |
| ovf | output | 1 | Overflow flag; reception blocked while set |
| cur_page | output | 8 | Current page (start of the next frame) |

## Verification
The bench aims at the page edges. A frame that ends on the last byte of a page must not link, and a design that links eagerly would abort there or skip a page in the next-frame pointer. A link out of the stop-1 page must wrap to the first page, and a design that checks the boundary before wrapping would run past the ring or miss an abort at the first page. The abort case checks that the offending byte is not written, that the current page is held, and that traffic during overflow is dropped. A design that kept writing would corrupt stored frames. Rejected and kept-bad frames, strobes overlapping the header writes, and boundary moves between frames round out the set. Any slip in header offsets or byte counts shows up as a mismatch against the reference model.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_RECV = 2'd1,
      RS_HDR  = 2'd2,
      RS_BLK  = 2'd3
   } rxr_state_e;

   localparam int RXR_HDR_BYTES = 4;
   localparam int RXR_HDR_IDX_W = $clog2(RXR_HDR_BYTES);
endpackage

// File: rtl/rxr_pgnext.sv
module rxr_pgnext #(
   parameter int PG_W = 8
) (
   input  logic [PG_W-1:0] pg,
   input  logic [PG_W-1:0] first_pg,
   input  logic [PG_W-1:0] stop_pg,
   output logic [PG_W-1:0] nxt
);
   logic [PG_W-1:0] inc;

   assign inc = pg + 1'b1;

   always_comb begin
      if (inc == stop_pg) nxt = first_pg;
      else                nxt = inc;
   end
endmodule

// File: rtl/rxr_hdrsel.sv
module rxr_hdrsel
   import rxr_pkg::*;
#(
   parameter int PG_W  = 8,
   parameter int CNT_W = 16
) (
   input  logic [RXR_HDR_IDX_W-1:0] idx,
   input  logic                     good,
   input  logic [PG_W-1:0]          nxt_pg,
   input  logic [CNT_W-1:0]         cnt,
   output logic [7:0]               hbyte
);
   localparam int CNT_BYTES = CNT_W / 8;

   logic [7:0] fld [RXR_HDR_BYTES];

   assign fld[0] = {6'b0, ~good, good};
   assign fld[1] = 8'(nxt_pg);

   for (genvar gi = 0; gi < CNT_BYTES; gi++) begin : g_cnt
      assign fld[2+gi] = cnt[gi*8 +: 8];
   end

   assign hbyte = fld[idx];
endmodule

// File: rtl/rxr_pager.sv
module rxr_pager
   import rxr_pkg::*;
#(
   parameter int PG_W  = 8,
   parameter int OFS_W = 8,
   parameter int CNT_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PG_W-1:0]       cfg_start,
   input  logic [PG_W-1:0]       cfg_stop,
   input  logic                  cfg_keep_bad,
   input  logic                  bnd_we,
   input  logic [PG_W-1:0]       bnd_page,
   input  logic                  rx_vld,
   input  logic [7:0]            rx_byte,
   input  logic                  rx_eof,
   input  logic                  rx_good,
   input  logic                  ovf_clr,
   output logic                  wr_en,
   output logic [PG_W+OFS_W-1:0] wr_addr,
   output logic [7:0]            wr_data,
   output logic                  rx_abort,
   output logic                  ovf,
   output logic [PG_W-1:0]       cur_page
);
   localparam int AW = PG_W + OFS_W;
   localparam logic [OFS_W-1:0] OFS_FIRST  = OFS_W'(RXR_HDR_BYTES);
   localparam logic [OFS_W-1:0] OFS_SECOND = OFS_W'(RXR_HDR_BYTES + 1);
   localparam logic [OFS_W-1:0] OFS_LAST   = '1;
   localparam logic [RXR_HDR_IDX_W-1:0] HIDX_LAST = RXR_HDR_IDX_W'(RXR_HDR_BYTES - 1);

   if (PG_W > 8) begin : g_chk_pg
      $error("rxr_pager: page number must fit the header byte");
   end
   if (CNT_W != 16) begin : g_chk_cnt
      $error("rxr_pager: header carries a two-byte count");
   end
   if (OFS_W <= $clog2(RXR_HDR_BYTES + 1)) begin : g_chk_ofs
      $error("rxr_pager: page too small for the header");
   end

   rxr_state_e             st_q;
   logic [PG_W-1:0]        cur_q, bnd_q, pg_q, nxt_q;
   logic [OFS_W-1:0]       ofs_q;
   logic                   lnk_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [RXR_HDR_IDX_W-1:0] hidx_q;
   logic                   good_q;
   logic                   wen_q, abort_q, ovf_q;
   logic [AW-1:0]          waddr_q;
   logic [7:0]             wdat_q;
   logic [PG_W-1:0]        nx_pg;
   logic [7:0]             hdr_byte;

   rxr_pgnext #(.PG_W(PG_W)) u_pgnext (
      .pg       (pg_q),
      .first_pg (cfg_start),
      .stop_pg  (cfg_stop),
      .nxt      (nx_pg)
   );

   rxr_hdrsel #(.PG_W(PG_W), .CNT_W(CNT_W)) u_hdrsel (
      .idx    (hidx_q),
      .good   (good_q),
      .nxt_pg (nxt_q),
      .cnt    (cnt_q),
      .hbyte  (hdr_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= RS_IDLE;
         cur_q   <= cfg_start;
         bnd_q   <= cfg_start;
         pg_q    <= cfg_start;
         nxt_q   <= cfg_start;
         ofs_q   <= '0;
         lnk_q   <= 1'b0;
         cnt_q   <= '0;
         hidx_q  <= '0;
         good_q  <= 1'b0;
         wen_q   <= 1'b0;
         waddr_q <= '0;
         wdat_q  <= '0;
         abort_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         wen_q   <= 1'b0;
         abort_q <= 1'b0;
         nxt_q   <= nx_pg;
         if (bnd_we) bnd_q <= bnd_page;
         case (st_q)
            RS_IDLE: begin
               pg_q <= cur_q;
               if (rx_vld && !rx_eof) begin
                  wen_q   <= 1'b1;
                  waddr_q <= {cur_q, OFS_FIRST};
                  wdat_q  <= rx_byte;
                  pg_q    <= cur_q;
                  ofs_q   <= OFS_SECOND;
                  lnk_q   <= 1'b0;
                  cnt_q   <= CNT_W'(1);
                  st_q    <= RS_RECV;
               end
            end
            RS_RECV: begin
               if (rx_eof) begin
                  if (rx_good || cfg_keep_bad) begin
                     st_q   <= RS_HDR;
                     hidx_q <= '0;
                     good_q <= rx_good;
                  end else begin
                     st_q   <= RS_IDLE;
                  end
               end else if (rx_vld) begin
                  if (lnk_q) begin
                     if (nx_pg == bnd_q) begin
                        abort_q <= 1'b1;
                        ovf_q   <= 1'b1;
                        st_q    <= RS_BLK;
                     end else begin
                        wen_q   <= 1'b1;
                        waddr_q <= {nx_pg, {OFS_W{1'b0}}};
                        wdat_q  <= rx_byte;
                        pg_q    <= nx_pg;
                        ofs_q   <= OFS_W'(1);
                        lnk_q   <= 1'b0;
                        cnt_q   <= cnt_q + 1'b1;
                     end
                  end else begin
                     wen_q   <= 1'b1;
                     waddr_q <= {pg_q, ofs_q};
                     wdat_q  <= rx_byte;
                     ofs_q   <= ofs_q + 1'b1;
                     cnt_q   <= cnt_q + 1'b1;
                     if (ofs_q == OFS_LAST) lnk_q <= 1'b1;
                  end
               end
            end
            RS_HDR: begin
               wen_q   <= 1'b1;
               waddr_q <= {cur_q, OFS_W'(hidx_q)};
               wdat_q  <= hdr_byte;
               hidx_q  <= hidx_q + 1'b1;
               if (hidx_q == HIDX_LAST) begin
                  cur_q <= nxt_q;
                  st_q  <= RS_IDLE;
               end
            end
            RS_BLK: begin
               if (ovf_clr) begin
                  ovf_q <= 1'b0;
                  st_q  <= RS_IDLE;
               end
            end
            default: st_q <= RS_IDLE;
         endcase
      end
   end

   assign wr_en    = wen_q;
   assign wr_addr  = waddr_q;
   assign wr_data  = wdat_q;
   assign rx_abort = abort_q;
   assign ovf      = ovf_q;
   assign cur_page = cur_q;
endmodule

// File: rtl/rxr_pager_chk.sv
module rxr_pager_chk #(
   parameter int PG_W  = 8,
   parameter int OFS_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [PG_W-1:0]       cfg_start,
   input logic [PG_W-1:0]       cfg_stop,
   input logic                  wr_en,
   input logic [PG_W+OFS_W-1:0] wr_addr,
   input logic                  rx_abort,
   input logic                  ovf,
   input logic [PG_W-1:0]       cur_page
);
   localparam int AW = PG_W + OFS_W;

   // R1: every write lands inside the ring
   a_r1_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (cfg_start < cfg_stop)) |->
         ((wr_addr[AW-1:OFS_W] >= cfg_start) && (wr_addr[AW-1:OFS_W] < cfg_stop)));

   // R8: an abort raises the overflow flag in the same cycle
   a_r8_abort_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      rx_abort |-> ovf);

   // R8: abort is a single-cycle pulse
   a_r8_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_abort |=> !rx_abort);

   // R9: no writes while blocked
   a_r9_blocked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> !wr_en);

   // R8: current page is held while blocked
   a_r8_cur_held: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> $stable(cur_page));
endmodule

bind rxr_pager rxr_pager_chk #(.PG_W(PG_W), .OFS_W(OFS_W)) u_rxr_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_start (cfg_start),
   .cfg_stop  (cfg_stop),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .rx_abort  (rx_abort),
   .ovf       (ovf),
   .cur_page  (cur_page)
);

// File: tb/test_rxr_pager.sv
module test_rxr_pager;
   localparam int START = 16'h10;
   localparam int STOP  = 16'h14;
   localparam int RING_BYTES = (STOP - START) * 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_start = 8'(START);
   logic [7:0]  cfg_stop  = 8'(STOP);
   logic        cfg_keep_bad = 1'b0;
   logic        bnd_we = 1'b0;
   logic [7:0]  bnd_page = '0;
   logic        rx_vld = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_eof = 1'b0;
   logic        rx_good = 1'b0;
   logic        ovf_clr = 1'b0;
   logic        wr_en;
   logic [15:0] wr_addr;
   logic [7:0]  wr_data;
   logic        rx_abort;
   logic        ovf;
   logic [7:0]  cur_page;

   rxr_pager i_rxr_pager (
      .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_stop(cfg_stop),
      .cfg_keep_bad(cfg_keep_bad), .bnd_we(bnd_we), .bnd_page(bnd_page),
      .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_eof(rx_eof), .rx_good(rx_good),
      .ovf_clr(ovf_clr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rx_abort(rx_abort), .ovf(ovf), .cur_page(cur_page)
   );

   always #4 clk = ~clk;

   int total = 0;
   int bad = 0;
   string tag = "R11";
   logic [7:0] bmem [RING_BYTES];
   bit   abort_seen = 0;
   int   cyc = 0;

   // behavioural reference model
   int m_st, m_cur, m_bnd, m_last, m_cnt, m_hi, m_good, m_nextpg, m_nb, m_np, m_a;
   bit e_wen, e_abort, e_ovf;
   int e_addr, e_dat;

   function automatic int ring_next(int p);
      return (p + 1 == STOP) ? START : p + 1;
   endfunction

   always @(posedge clk) begin
      e_wen = 0;
      e_abort = 0;
      if (!rst_n) begin
         m_st = 0; m_cur = START; m_bnd = START; e_ovf = 0;
         e_addr = 0; e_dat = 0; m_last = 0; m_cnt = 0;
      end else begin
         m_nb = bnd_we ? int'(bnd_page) : m_bnd;
         case (m_st)
            0: if (rx_vld && !rx_eof) begin
                  m_last = m_cur * 256 + 4;
                  e_wen = 1; e_addr = m_last; e_dat = int'(rx_byte);
                  m_cnt = 1; m_st = 1;
               end
            1: if (rx_eof) begin
                  if (rx_good || cfg_keep_bad) begin
                     m_st = 2; m_hi = 0; m_good = int'(rx_good);
                     m_nextpg = ring_next(m_last / 256);
                  end else m_st = 0;
               end else if (rx_vld) begin
                  m_a = -1;
                  if (m_last % 256 == 255) begin
                     m_np = ring_next(m_last / 256);
                     if (m_np == m_bnd) begin
                        e_abort = 1; e_ovf = 1; m_st = 3;
                     end else m_a = m_np * 256;
                  end else m_a = m_last + 1;
                  if (m_a >= 0) begin
                     m_last = m_a; m_cnt++;
                     e_wen = 1; e_addr = m_a; e_dat = int'(rx_byte);
                  end
               end
            2: begin
                  e_wen = 1; e_addr = m_cur * 256 + m_hi;
                  case (m_hi)
                     0: e_dat = m_good ? 1 : 2;
                     1: e_dat = m_nextpg;
                     2: e_dat = m_cnt % 256;
                     default: e_dat = (m_cnt / 256) % 256;
                  endcase
                  m_hi++;
                  if (m_hi == 4) begin m_cur = m_nextpg; m_st = 0; end
               end
            default: if (ovf_clr) begin e_ovf = 0; m_st = 0; end
         endcase
         m_bnd = m_nb;
      end
   end

   // per-cycle comparison against the model, and memory image
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         total++;
         if (wr_en !== e_wen || rx_abort !== e_abort || ovf !== e_ovf ||
             int'(cur_page) != m_cur ||
             (e_wen && (int'(wr_addr) != e_addr || int'(wr_data) != e_dat))) begin
            bad++;
            $display("FAIL %s cycle %0d: wen=%0b addr=%h data=%h abort=%0b ovf=%0b cur=%h expected wen=%0b addr=%h data=%h abort=%0b ovf=%0b cur=%h",
                     tag, cyc, wr_en, wr_addr, wr_data, rx_abort, ovf, cur_page,
                     e_wen, e_addr, e_dat, e_abort, e_ovf, m_cur);
         end
         if (wr_en && int'(wr_addr) >= START * 256 && int'(wr_addr) < STOP * 256)
            bmem[int'(wr_addr) - START * 256] = wr_data;
         if (rx_abort) abort_seen = 1;
      end
      if (cyc > 100000) begin
         bad++; total++;
         $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 100000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(string t, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
      end
   endtask

   task automatic step(bit v, logic [7:0] b, bit e, bit g);
      @(negedge clk);
      rx_vld = v; rx_byte = b; rx_eof = e; rx_good = g;
   endtask

   task automatic quiet(int n);
      for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0);
   endtask

   task automatic frame(int n, bit g, int seed);
      for (int i = 0; i < n; i++) begin
         if (i % 7 == 3) step(0, 8'h00, 0, 0);
         step(1, 8'((seed + i * 3) % 256), 0, 0);
      end
      step(0, 8'h00, 1, g);
      quiet(6);
   endtask

   task automatic set_bnd(int p);
      @(negedge clk);
      bnd_we = 1; bnd_page = 8'(p);
      @(negedge clk);
      bnd_we = 0;
   endtask

   function automatic int hdr(int pg, int ofs);
      return int'(bmem[(pg - START) * 256 + ofs]);
   endfunction

   initial begin
      quiet(3);
      // R11: reset state
      check("R11 cur_page after reset", int'(cur_page), START);
      check("R11 ovf after reset", int'(ovf), 0);
      check("R11 no write in reset", int'(wr_en), 0);
      rst_n = 1;
      quiet(2);

      tag = "R2";
      frame(60, 1, 7);
      check("R2 first data byte at offset 4", hdr(START, 4), 7);
      check("R4 status good", hdr(START, 0), 1);
      check("R4 next-frame page", hdr(START, 1), START + 1);
      check("R4 count low", hdr(START, 2), 60);
      check("R4 count high", hdr(START, 3), 0);
      check("R5 cur_page after frame", int'(cur_page), START + 1);

      tag = "R3";
      frame(300, 1, 40);
      check("R3 link continues at offset 0 of next page", hdr(START + 2, 0), (40 + 252 * 3) % 256);
      check("R4 count over page", hdr(START + 1, 2) + 256 * hdr(START + 1, 3), 300);
      check("R5 cur_page after linked frame", int'(cur_page), START + 3);

      tag = "R6";
      frame(100, 0, 90);
      check("R6 rejected frame keeps cur_page", int'(cur_page), START + 3);

      tag = "R7";
      set_bnd(START + 1);
      cfg_keep_bad = 1;
      frame(300, 0, 11);
      cfg_keep_bad = 0;
      check("R7 kept bad status", hdr(START + 3, 0), 2);
      check("R1 next-frame page wraps", hdr(START + 3, 1), START + 1);
      check("R1 cur_page wraps", int'(cur_page), START + 1);

      tag = "R8";
      set_bnd(START + 3);
      frame(600, 1, 5);
      check("R8 abort pulse seen", int'(abort_seen), 1);
      check("R8 ovf set", int'(ovf), 1);
      check("R8 cur_page held", int'(cur_page), START + 1);

      tag = "R9";
      frame(5, 1, 200);
      check("R9 blocked frame ignored", int'(cur_page), START + 1);
      @(negedge clk); ovf_clr = 1;
      @(negedge clk); ovf_clr = 0;
      check("R9 ovf cleared", int'(ovf), 0);
      frame(10, 1, 77);
      check("R9 restart at cur_page offset 4", hdr(START + 1, 4), 77);
      check("R9 cur_page after restart", int'(cur_page), START + 2);

      tag = "R10";
      frame(252, 1, 33);
      check("R3 exact page fill no abort", int'(ovf), 0);
      check("R10 cur_page reaches boundary page", int'(cur_page), START + 3);
      frame(1, 1, 9);
      check("R1 single byte frame wraps", int'(cur_page), START);

      tag = "R12";
      step(0, 8'h00, 1, 1);
      step(1, 8'h55, 1, 1);
      step(1, 8'hA1, 0, 0);
      step(1, 8'hA2, 0, 0);
      step(0, 8'h00, 1, 1);
      step(1, 8'hB1, 0, 0);
      step(1, 8'hB2, 0, 0);
      step(1, 8'hB3, 0, 0);
      quiet(6);
      check("R12 count ignores header-time strobes", hdr(START, 2), 2);
      check("R12 cur_page after overlap", int'(cur_page), START + 1);

      quiet(4);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule